// File: doc/BRIEF.md
# PCIe MSI and INTx interrupt aggregator

This block gathers every interrupt source a PCIe root-complex wrapper has to deliver to the host: 32 message-signalled vectors, 4 legacy INTx lines and 6 error events. Sources arrive as one-cycle pulses. MSI vectors can also arrive through a doorbell register, where a write to the doorbell offset carries the vector number as data. Each source has a pending bit and an enable bit. Every MSI group and every INTx line drives its own level interrupt output. The error set drives one summary output and one fatal-class output.

The MSI vectors are interleaved across 8 groups of 4 bits. Vector v lives in group v mod 8 at bit v div 8. A driver services one group, clears the bits it handled by writing ones to the status register, and then writes the end-of-interrupt register. That write drops the group output for one cycle, so a downstream edge detector sees a new edge if work is still pending. Enables have separate set and clear registers, so no read-modify-write is needed. Error status can be read either unfiltered or filtered through the enables.

Top module: `pcie_irq_agg`

## Requirements
- R1: A pulse on MSI vector v sets bit v/8 of the status register of group g = v mod 8. That register is at offset 0x104 + 0x10·g and holds bits 3:0.
- R2: Writing a 1 to a status bit clears that pending bit. Zero bits in the write leave their bits unchanged. This applies to MSI status, INTx status and masked error status.
- R3: Writing ones to 0x108 + 0x10·g enables those bits of group g. Writing ones to 0x10C + 0x10·g disables them. Both offsets read back the current enable mask.
- R4: msi_irq_o[g] is high, one cycle after the state is registered, while any bit of group g is both pending and enabled.
- R5: A write to 0x050 with value 4+g forces msi_irq_o[g] low for the next cycle. A write of value n in 0..3 does the same for intx_irq_o[n]. Other values have no effect.
- R6: A write of value v < 32 to 0x054 sets the pending bit of vector v. Values of 32 or more are ignored.
- R7: INTx line n has its pending flag in bit 0 of 0x184 + 0x10·n, enable-set at 0x188 + 0x10·n and enable-clear at 0x18C + 0x10·n. intx_irq_o[n] follows the R4 rule for that line.
- R8: The error bits are 0 system, 1 fatal, 2 non-fatal, 3 correctable, 4 tag-lookup fatal and 5 ECRC. 0x1C0 reads the unfiltered status and ignores writes. 0x1C4 reads status AND enable and is write-1-to-clear. 0x1C8 is enable-set and 0x1CC is enable-clear. err_irq_o is high while any error bit is pending and enabled.
- R9: err_fatal_o is high, with the same latency as err_irq_o, while bit 1 or bit 4 is pending and enabled.
- R10: If a source pulse and a write-1-to-clear of the same bit occur in the same cycle, the bit stays pending.
- R11: Every register and output is zero after reset. Unmapped offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| msi_evt_i | input | 32 | One pulse bit per MSI vector |
| intx_evt_i | input | 4 | One pulse bit per INTx line |
| err_evt_i | input | 6 | One pulse bit per error source |
| msi_irq_o | output | 8 | Per-group MSI interrupt |
| intx_irq_o | output | 4 | Per-line INTx interrupt |
| err_irq_o | output | 1 | Any enabled error pending |
| err_fatal_o | output | 1 | Enabled fatal-class error pending |

## Verification
The bound checker watches properties on every cycle. For every vector it checks that a pulse always lands in the interleaved group and bit, including when a same-cycle clear collides with it. It also checks that a group output is only ever raised by an enabled pending bit, that an end-of-interrupt write always drops the matching output, that the fatal output never appears without the summary error output, and that offsets above the map read zero. Some behaviour can only be shown by the bench's scenarios. This covers the register read-back values, the doorbell range cut-off, write-1-to-clear with mixed zero bits, the read-only unfiltered error register, the re-arm of an output after its one-cycle drop, and ignored writes to holes in the map.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
  localparam int unsigned REG_STRIDE = 16;
  localparam int unsigned OFS_STAT   = 4;
  localparam int unsigned OFS_SET    = 8;
  localparam int unsigned OFS_CLR    = 12;
  localparam int unsigned EOI_OFS    = 'h050;
  localparam int unsigned DBELL_OFS  = 'h054;
  localparam int unsigned MSI_BASE   = 'h100;
  localparam int unsigned INTX_BASE  = 'h180;
  localparam int unsigned ERR_BASE   = 'h1C0;
  localparam logic [5:0]  ERR_FATAL_MASK = 6'b01_0010;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] w1c_i,
  input  logic [W-1:0] en_set_i,
  input  logic [W-1:0] en_clr_i,
  input  logic         eoi_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q, en_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      // a new pulse beats a same-cycle clear
      pend_q <= (pend_q & ~w1c_i) | evt_i;
      en_q   <= (en_q | en_set_i) & ~en_clr_i;
      irq_q  <= (|(pend_q & en_q)) && !eoi_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/msi_vec_route.sv
module msi_vec_route #(
  parameter int unsigned N_GRP = 8,
  parameter int unsigned GRP_W = 4
) (
  input  logic [N_GRP*GRP_W-1:0]          vec_i,
  output logic [N_GRP-1:0][GRP_W-1:0]     grp_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    for (genvar b = 0; b < GRP_W; b++) begin : g_bit
      assign grp_o[g][b] = vec_i[g + N_GRP*b];
    end
  end
endmodule

// File: rtl/pcie_irq_agg.sv
module pcie_irq_agg
  import pcie_irq_pkg::*;
#(
  parameter int unsigned N_GRP  = 8,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned N_INTX = 4,
  parameter int unsigned ERR_W  = 6,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic [AW-1:0]           reg_addr_i,
  input  logic [DW-1:0]           reg_wdata_i,
  output logic [DW-1:0]           reg_rdata_o,
  input  logic [N_GRP*GRP_W-1:0]  msi_evt_i,
  input  logic [N_INTX-1:0]       intx_evt_i,
  input  logic [ERR_W-1:0]        err_evt_i,
  output logic [N_GRP-1:0]        msi_irq_o,
  output logic [N_INTX-1:0]       intx_irq_o,
  output logic                    err_irq_o,
  output logic                    err_fatal_o
);
  localparam int unsigned N_VEC  = N_GRP * GRP_W;
  localparam int unsigned VEC_IW = $clog2(N_VEC);
  localparam int unsigned N_EOI  = N_INTX + N_GRP;

  logic [N_VEC-1:0]              dbell_vec;
  logic [N_GRP-1:0][GRP_W-1:0]   grp_evt;
  logic [N_GRP-1:0][GRP_W-1:0]   msi_pend, msi_en;
  logic [N_GRP-1:0]              m_st, m_set, m_clr;
  logic [N_INTX-1:0]             ix_pend, ix_en, i_st, i_set, i_clr;
  logic [ERR_W-1:0]              err_pend, err_en;
  logic [N_EOI-1:0]              eoi_hit;
  logic                          e_raw, e_msk, e_set, e_clr;
  logic                          err_fatal_q;

  always_comb begin
    dbell_vec = '0;
    if (reg_wr_i && reg_addr_i == AW'(DBELL_OFS) && reg_wdata_i < DW'(N_VEC))
      dbell_vec[reg_wdata_i[VEC_IW-1:0]] = 1'b1;
  end

  msi_vec_route #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_route (
    .vec_i (msi_evt_i | dbell_vec),
    .grp_o (grp_evt)
  );

  for (genvar k = 0; k < N_EOI; k++) begin : g_eoi
    assign eoi_hit[k] = reg_wr_i && reg_addr_i == AW'(EOI_OFS) && reg_wdata_i == DW'(k);
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_msi
    assign m_st[g]  = reg_addr_i == AW'(MSI_BASE + REG_STRIDE*g + OFS_STAT);
    assign m_set[g] = reg_addr_i == AW'(MSI_BASE + REG_STRIDE*g + OFS_SET);
    assign m_clr[g] = reg_addr_i == AW'(MSI_BASE + REG_STRIDE*g + OFS_CLR);
    irq_src_bank #(.W(GRP_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (grp_evt[g]),
      .w1c_i    ((reg_wr_i && m_st[g])  ? reg_wdata_i[GRP_W-1:0] : '0),
      .en_set_i ((reg_wr_i && m_set[g]) ? reg_wdata_i[GRP_W-1:0] : '0),
      .en_clr_i ((reg_wr_i && m_clr[g]) ? reg_wdata_i[GRP_W-1:0] : '0),
      .eoi_i    (eoi_hit[N_INTX+g]),
      .pend_o   (msi_pend[g]),
      .en_o     (msi_en[g]),
      .irq_o    (msi_irq_o[g])
    );
  end

  for (genvar n = 0; n < N_INTX; n++) begin : g_intx
    assign i_st[n]  = reg_addr_i == AW'(INTX_BASE + REG_STRIDE*n + OFS_STAT);
    assign i_set[n] = reg_addr_i == AW'(INTX_BASE + REG_STRIDE*n + OFS_SET);
    assign i_clr[n] = reg_addr_i == AW'(INTX_BASE + REG_STRIDE*n + OFS_CLR);
    irq_src_bank #(.W(1)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (intx_evt_i[n]),
      .w1c_i    (reg_wr_i && i_st[n]  && reg_wdata_i[0]),
      .en_set_i (reg_wr_i && i_set[n] && reg_wdata_i[0]),
      .en_clr_i (reg_wr_i && i_clr[n] && reg_wdata_i[0]),
      .eoi_i    (eoi_hit[n]),
      .pend_o   (ix_pend[n]),
      .en_o     (ix_en[n]),
      .irq_o    (intx_irq_o[n])
    );
  end

  assign e_raw = reg_addr_i == AW'(ERR_BASE);
  assign e_msk = reg_addr_i == AW'(ERR_BASE + OFS_STAT);
  assign e_set = reg_addr_i == AW'(ERR_BASE + OFS_SET);
  assign e_clr = reg_addr_i == AW'(ERR_BASE + OFS_CLR);

  irq_src_bank #(.W(ERR_W)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (err_evt_i),
    .w1c_i    ((reg_wr_i && e_msk) ? reg_wdata_i[ERR_W-1:0] : '0),
    .en_set_i ((reg_wr_i && e_set) ? reg_wdata_i[ERR_W-1:0] : '0),
    .en_clr_i ((reg_wr_i && e_clr) ? reg_wdata_i[ERR_W-1:0] : '0),
    .eoi_i    (1'b0),
    .pend_o   (err_pend),
    .en_o     (err_en),
    .irq_o    (err_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_fatal_q <= 1'b0;
    else         err_fatal_q <= |(err_pend & err_en & ERR_W'(ERR_FATAL_MASK));
  end
  assign err_fatal_o = err_fatal_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (m_st[g])            reg_rdata_o[GRP_W-1:0] = msi_pend[g];
      if (m_set[g] | m_clr[g]) reg_rdata_o[GRP_W-1:0] = msi_en[g];
    end
    for (int n = 0; n < N_INTX; n++) begin
      if (i_st[n])             reg_rdata_o[0] = ix_pend[n];
      if (i_set[n] | i_clr[n]) reg_rdata_o[0] = ix_en[n];
    end
    if (e_raw)         reg_rdata_o[ERR_W-1:0] = err_pend;
    if (e_msk)         reg_rdata_o[ERR_W-1:0] = err_pend & err_en;
    if (e_set | e_clr) reg_rdata_o[ERR_W-1:0] = err_en;
  end
endmodule

// File: rtl/pcie_irq_agg_chk.sv
module pcie_irq_agg_chk
  import pcie_irq_pkg::*;
#(
  parameter int unsigned N_GRP  = 8,
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned N_INTX = 4,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        reg_wr_i,
  input logic [AW-1:0]               reg_addr_i,
  input logic [DW-1:0]               reg_wdata_i,
  input logic [DW-1:0]               reg_rdata_o,
  input logic [N_GRP*GRP_W-1:0]      msi_evt_i,
  input logic [N_GRP-1:0]            msi_irq_o,
  input logic                        err_irq_o,
  input logic                        err_fatal_o,
  input logic [N_GRP-1:0][GRP_W-1:0] msi_pend,
  input logic [N_GRP-1:0][GRP_W-1:0] msi_en
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    // R4
    grp_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && msi_irq_o[g]) |-> $past(|(msi_pend[g] & msi_en[g])));
    // R5
    eoi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_addr_i == AW'(EOI_OFS) && reg_wdata_i == DW'(N_INTX + g))
      |=> !msi_irq_o[g]);
  end

  for (genvar v = 0; v < N_GRP*GRP_W; v++) begin : g_vec
    localparam int unsigned G = v % N_GRP;
    localparam int unsigned B = v / N_GRP;
    // R1 R10
    evt_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msi_evt_i[v] |=> msi_pend[G][B]);
  end

  // R9
  fatal_in_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_fatal_o |-> err_irq_o);

  // R11
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i >= AW'('h200)) |-> reg_rdata_o == '0);
endmodule

bind pcie_irq_agg pcie_irq_agg_chk #(
  .N_GRP(N_GRP), .GRP_W(GRP_W), .N_INTX(N_INTX), .AW(AW), .DW(DW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .msi_evt_i   (msi_evt_i),
  .msi_irq_o   (msi_irq_o),
  .err_irq_o   (err_irq_o),
  .err_fatal_o (err_fatal_o),
  .msi_pend    (msi_pend),
  .msi_en      (msi_en)
);

// File: tb/pcie_irq_agg_tb.sv
module pcie_irq_agg_tb;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_EVM = 3'd2,
                         OP_EVI = 3'd3, OP_EVE = 3'd4, OP_IRQ = 3'd5, OP_IDLE = 3'd6;
  localparam int NSTEP = 59;
  // {req, op, addr, data, expected}; IRQ expected = {fatal, err, intx[3:0], msi[7:0]}
  localparam logic [82:0] TBL [NSTEP] = '{
    {4'd3,  OP_WR,  12'h108, 32'hF,   32'h0},   // R3
    {4'd3,  OP_RD,  12'h108, 32'h0,   32'hF},   // R3
    {4'd1,  OP_EVM, 12'h000, 32'h100, 32'h0},   // R1 vector 8
    {4'd1,  OP_RD,  12'h104, 32'h0,   32'h2},   // R1
    {4'd4,  OP_IRQ, 12'h000, 32'h0,   32'h001}, // R4
    {4'd5,  OP_WR,  12'h050, 32'h4,   32'h0},   // R5
    {4'd5,  OP_IRQ, 12'h000, 32'h0,   32'h000}, // R5
    {4'd5,  OP_IRQ, 12'h000, 32'h0,   32'h001}, // R5
    {4'd2,  OP_WR,  12'h104, 32'h2,   32'h0},   // R2
    {4'd2,  OP_RD,  12'h104, 32'h0,   32'h0},   // R2
    {4'd4,  OP_IRQ, 12'h000, 32'h0,   32'h000}, // R4
    {4'd6,  OP_WR,  12'h054, 32'd21,  32'h0},   // R6
    {4'd6,  OP_RD,  12'h154, 32'h0,   32'h4},   // R6
    {4'd6,  OP_WR,  12'h054, 32'd40,  32'h0},   // R6
    {4'd6,  OP_RD,  12'h104, 32'h0,   32'h0},   // R6
    {4'd3,  OP_WR,  12'h158, 32'h4,   32'h0},   // R3
    {4'd3,  OP_RD,  12'h15C, 32'h0,   32'h4},   // R3
    {4'd4,  OP_IRQ, 12'h000, 32'h0,   32'h020}, // R4
    {4'd3,  OP_WR,  12'h15C, 32'h4,   32'h0},   // R3
    {4'd4,  OP_IRQ, 12'h000, 32'h0,   32'h020}, // R4
    {4'd3,  OP_IRQ, 12'h000, 32'h0,   32'h000}, // R3
    {4'd2,  OP_WR,  12'h154, 32'h4,   32'h0},   // R2
    {4'd2,  OP_RD,  12'h154, 32'h0,   32'h0},   // R2
    {4'd7,  OP_WR,  12'h1A8, 32'h1,   32'h0},   // R7
    {4'd7,  OP_EVI, 12'h000, 32'h4,   32'h0},   // R7
    {4'd7,  OP_RD,  12'h1A4, 32'h0,   32'h1},   // R7
    {4'd7,  OP_IRQ, 12'h000, 32'h0,   32'h400}, // R7
    {4'd5,  OP_WR,  12'h050, 32'h2,   32'h0},   // R5
    {4'd5,  OP_IRQ, 12'h000, 32'h0,   32'h000}, // R5
    {4'd5,  OP_IRQ, 12'h000, 32'h0,   32'h400}, // R5
    {4'd5,  OP_WR,  12'h050, 32'hC,   32'h0},   // R5
    {4'd5,  OP_IRQ, 12'h000, 32'h0,   32'h400}, // R5
    {4'd7,  OP_WR,  12'h1A4, 32'h1,   32'h0},   // R7
    {4'd7,  OP_RD,  12'h1A4, 32'h0,   32'h0},   // R7
    {4'd7,  OP_IRQ, 12'h000, 32'h0,   32'h000}, // R7
    {4'd8,  OP_WR,  12'h1C8, 32'h13,  32'h0},   // R8
    {4'd8,  OP_EVE, 12'h000, 32'h0C,  32'h0},   // R8
    {4'd8,  OP_RD,  12'h1C0, 32'h0,   32'h0C},  // R8
    {4'd8,  OP_RD,  12'h1C4, 32'h0,   32'h00},  // R8
    {4'd8,  OP_IRQ, 12'h000, 32'h0,   32'h000}, // R8
    {4'd9,  OP_EVE, 12'h000, 32'h10,  32'h0},   // R9
    {4'd8,  OP_RD,  12'h1C4, 32'h0,   32'h10},  // R8
    {4'd9,  OP_IRQ, 12'h000, 32'h0,   32'h3000},// R9
    {4'd8,  OP_WR,  12'h1C4, 32'h10,  32'h0},   // R8
    {4'd8,  OP_RD,  12'h1C0, 32'h0,   32'h0C},  // R8
    {4'd9,  OP_IRQ, 12'h000, 32'h0,   32'h000}, // R9
    {4'd9,  OP_EVE, 12'h000, 32'h01,  32'h0},   // R9
    {4'd8,  OP_RD,  12'h1C4, 32'h0,   32'h01},  // R8
    {4'd9,  OP_IRQ, 12'h000, 32'h0,   32'h1000},// R9
    {4'd8,  OP_WR,  12'h1C0, 32'h3F,  32'h0},   // R8
    {4'd8,  OP_RD,  12'h1C0, 32'h0,   32'h0D},  // R8
    {4'd8,  OP_WR,  12'h1CC, 32'h13,  32'h0},   // R8
    {4'd8,  OP_RD,  12'h1C8, 32'h0,   32'h0},   // R8
    {4'd11, OP_WR,  12'h100, 32'hFFFFFFFF, 32'h0}, // R11
    {4'd11, OP_RD,  12'h100, 32'h0,   32'h0},   // R11
    {4'd11, OP_RD,  12'h108, 32'h0,   32'hF},   // R11
    {4'd11, OP_WR,  12'h1D0, 32'hFFFFFFFF, 32'h0}, // R11
    {4'd11, OP_RD,  12'h1D0, 32'h0,   32'h0},   // R11
    {4'd11, OP_RD,  12'h300, 32'h0,   32'h0}    // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] msi_evt = '0;
  logic [3:0]  intx_evt = '0;
  logic [5:0]  err_evt = '0;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;
  logic        err_irq, err_fatal;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pcie_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .msi_evt_i(msi_evt),
    .intx_evt_i(intx_evt), .err_evt_i(err_evt), .msi_irq_o(msi_irq),
    .intx_irq_o(intx_irq), .err_irq_o(err_irq), .err_fatal_o(err_fatal)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_step(input logic [2:0] op, input logic [11:0] addr,
                         input logic [31:0] data, input logic [31:0] exp, input int req);
    @(negedge clk);
    reg_wr = 1'b0; msi_evt = '0; intx_evt = '0; err_evt = '0;
    reg_addr = addr; reg_wdata = data;
    case (op)
      OP_WR:  reg_wr = 1'b1;
      OP_EVM: msi_evt = data;
      OP_EVI: intx_evt = data[3:0];
      OP_EVE: err_evt = data[5:0];
      default: ;
    endcase
    #1;
    if (op == OP_RD)  check(reg_rdata, exp, req);
    if (op == OP_IRQ) check({18'b0, err_fatal, err_irq, intx_irq, msi_irq}, exp, req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    do_step(OP_RD,  12'h104, 0, 0, 11);
    do_step(OP_RD,  12'h188, 0, 0, 11);
    do_step(OP_RD,  12'h1C0, 0, 0, 11);
    do_step(OP_IRQ, 12'h000, 0, 0, 11);

    for (int i = 0; i < NSTEP; i++)
      do_step(TBL[i][78:76], TBL[i][75:64], TBL[i][63:32], TBL[i][31:0], int'(TBL[i][82:79]));
    do_step(OP_IDLE, 12'h000, 0, 0, 0);

    // R10 pulse and clear of the same bit in one cycle (vector 3 -> group 3 bit 0)
    @(negedge clk);
    msi_evt = 32'h8; reg_wr = 1'b1; reg_addr = 12'h134; reg_wdata = 32'h1;
    @(negedge clk);
    msi_evt = '0; reg_wr = 1'b0;
    do_step(OP_RD, 12'h134, 0, 32'h1, 10);

    // R2 partial clear and zero-bit write (vectors 0 and 24 -> group 0 bits 0 and 3)
    do_step(OP_EVM, 12'h000, 32'h0100_0001, 0, 2);
    do_step(OP_WR,  12'h104, 32'h1, 0, 2);
    do_step(OP_RD,  12'h104, 0, 32'h8, 2);
    do_step(OP_WR,  12'h104, 32'h0, 0, 2);
    do_step(OP_RD,  12'h104, 0, 32'h8, 2);

    // R11 reset clears state set above
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_step(OP_RD,  12'h108, 0, 0, 11);
    do_step(OP_RD,  12'h104, 0, 0, 11);
    do_step(OP_RD,  12'h134, 0, 0, 11);
    do_step(OP_IRQ, 12'h000, 0, 0, 11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule